// File: doc/BRIEF.md
# Relative Branch Condition Unit

This block decides whether a conditional relative branch of an 8-bit accumulator processor is taken and produces the program counter value that follows it. It takes the current 16-bit program counter, the 8-bit branch offset operand, an already decoded 3-bit condition selector and the four status flags: negative, overflow, zero and carry.

When the selected flag holds the required value, the branch is taken. The next program counter is then the current counter plus the sign-extended offset, wrapping within the 16-bit address space. When the condition is false, the next program counter equals the current one. Both results are combinational. A registered copy of the next program counter is loaded on a clock edge when the valid input is high.

Page-crossing penalties, instruction fetch and opcode decoding are handled elsewhere.

Top module: `branch_cond_unit`

## Requirements
- R1: When the branch is taken, `next_pc_o` equals `pc_i` plus the offset, where the offset is interpreted as a signed 8-bit value; the counter is loaded with this address and never with a data byte.
- R2: Offsets 0x00 to 0x7F move the target forward by that amount, and offsets 0x80 to 0xFF move it backward by 256 minus the offset.
- R3: The target addition wraps modulo 65536 (for example, 0xFFF0 + 0x20 gives 0x0010, and 0x0000 + 0xFF gives 0xFFFF).
- R4: `sel_i[2:1]` picks the tested flag (00 = negative, 01 = overflow, 10 = carry, 11 = zero) and `sel_i[0]` gives the value that flag must have. `taken_o` is 1 exactly when the picked flag equals `sel_i[0]`, which gives all eight set and clear conditions.
- R5: When the condition is false, `next_pc_o` equals `pc_i`.
- R6: The three flags that the selector does not pick have no effect on `taken_o`.
- R7: On a rising clock edge with `valid_i` high, `pc_q_o` takes the value that `next_pc_o` had before that edge.
- R8: On a rising clock edge with `valid_i` low, `pc_q_o` keeps its value.
- R9: While `rst_n` is low, `pc_q_o` is reset to the parameter `RESET_PC` (default 0x0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Load the registered program counter on this edge |
| pc_i | input | 16 | Current program counter |
| offset_i | input | 8 | Signed branch offset operand |
| sel_i | input | 3 | Decoded condition: flag in [2:1], required value in [0] |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| taken_o | output | 1 | Branch condition holds |
| next_pc_o | output | 16 | Target if taken, otherwise `pc_i` |
| pc_q_o | output | 16 | Registered next program counter |

## Verification
`taken_o` and `next_pc_o` are due in the same cycle as their inputs. The bench therefore changes inputs on the falling edge and samples one nanosecond later, with no clock edge in between. `pc_q_o` is due one rising edge after a cycle in which `valid_i` is high. For this output, the bench drives on a falling edge and lets one rising edge pass. It then samples one nanosecond after that edge, and checks that the value is unchanged across edges in which `valid_i` is low. The condition logic is swept over every selector and flag combination, and the target over all 256 offsets at four counter values, including ones that wrap.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;
    localparam int unsigned FLAG_COUNT = 4;
    localparam int unsigned FLAG_IDX_W = $clog2(FLAG_COUNT);
    localparam int unsigned SEL_W      = FLAG_IDX_W + 1;

    // Flag vector order is fixed by the selector encoding (sel[2:1]).
    localparam int unsigned FIDX_NEG   = 0;
    localparam int unsigned FIDX_OVF   = 1;
    localparam int unsigned FIDX_CARRY = 2;
    localparam int unsigned FIDX_ZERO  = 3;

    typedef logic [FLAG_COUNT-1:0] flag_vec_t;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import branch_cond_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  flag_vec_t        flags_i,
    output logic             taken_o
);
    logic [FLAG_IDX_W-1:0] flag_idx;
    logic                  want_set;
    logic                  picked;

    always_comb begin
        flag_idx = sel_i[SEL_W-1:1];
        want_set = sel_i[0];
        picked   = flags_i[flag_idx];
        taken_o  = ~(picked ^ want_set);
    end
endmodule

// File: rtl/branch_target_add.sv
module branch_target_add #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 8
) (
    input  logic [PC_W-1:0]  base_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [PC_W-1:0]  target_o
);
    localparam int unsigned EXT_W = (PC_W > OFF_W) ? (PC_W - OFF_W) : 0;

    logic [PC_W-1:0] offset_ext;

    generate
        if (EXT_W > 0) begin : g_sext
            assign offset_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
        end else begin : g_trunc
            assign offset_ext = offset_i[PC_W-1:0];
        end
    endgenerate

    // Carry out of the top bit is discarded, so the sum wraps.
    assign target_o = base_i + offset_ext;
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import branch_cond_pkg::*;
#(
    parameter int unsigned          PC_W     = 16,
    parameter int unsigned          OFF_W    = 8,
    parameter logic [PC_W-1:0]      RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             flag_n_i,
    input  logic             flag_v_i,
    input  logic             flag_z_i,
    input  logic             flag_c_i,
    output logic             taken_o,
    output logic [PC_W-1:0]  next_pc_o,
    output logic [PC_W-1:0]  pc_q_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    flag_vec_t       flags;
    logic            cond_hit;
    logic [PC_W-1:0] target;
    state_t          state_d, state_q;

    always_comb begin
        flags             = '0;
        flags[FIDX_NEG]   = flag_n_i;
        flags[FIDX_OVF]   = flag_v_i;
        flags[FIDX_CARRY] = flag_c_i;
        flags[FIDX_ZERO]  = flag_z_i;
    end

    branch_cond_eval i_eval (
        .sel_i   (sel_i),
        .flags_i (flags),
        .taken_o (cond_hit)
    );

    branch_target_add #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) i_add (
        .base_i   (pc_i),
        .offset_i (offset_i),
        .target_o (target)
    );

    assign taken_o   = cond_hit;
    assign next_pc_o = cond_hit ? target : pc_i;
    assign pc_q_o    = state_q.pc;

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            state_d.pc = next_pc_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: a valid edge captures the pre-edge next counter
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (pc_q_o == $past(next_pc_o)));

    // R8: without valid the register holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pc_q_o));

    // R5: a failing condition leaves the counter where it is
    a_r5_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> (next_pc_o == pc_i));

    // R2: a forward offset without wrap never moves the counter back
    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !offset_i[OFF_W-1] && (pc_i < (PC_W'(1) << (PC_W-1))))
            |-> (next_pc_o >= pc_i));

    // R2: a backward offset without wrap moves the counter down
    a_r2_backward: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && offset_i[OFF_W-1] && (pc_i >= (PC_W'(1) << OFF_W)))
            |-> (next_pc_o < pc_i));

    // R4: zero flag matching the required value always takes the branch
    a_r4_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_i[SEL_W-1:1] == 2'b11) && (flag_z_i == sel_i[0])) |-> taken_o);
endmodule

// File: tb/test_branch_cond_unit.sv
`timescale 1ns/1ps
module test_branch_cond_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] pc_i = 16'h0;
    logic [7:0]  offset_i = 8'h0;
    logic [2:0]  sel_i = 3'b0;
    logic        flag_n_i = 1'b0, flag_v_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0;
    logic        taken_o;
    logic [15:0] next_pc_o, pc_q_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    branch_cond_unit i_branch_cond_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i),
        .offset_i(offset_i), .sel_i(sel_i), .flag_n_i(flag_n_i),
        .flag_v_i(flag_v_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .pc_q_o(pc_q_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model_taken(input logic [2:0] s, input logic [3:0] f);
        // f = {Z, C, V, N}; selector 00=N 01=V 10=C 11=Z, bit0 = required value
        logic fl;
        case (s[2:1])
            2'b00: fl = f[0];
            2'b01: fl = f[1];
            2'b10: fl = f[2];
            default: fl = f[3];
        endcase
        return fl == s[0];
    endfunction

    function automatic logic [15:0] model_target(input logic [15:0] pc, input logic [7:0] off);
        int t;
        t = int'(pc) + int'(off) - (off >= 8'h80 ? 256 : 0);
        return 16'((t + 65536) % 65536);
    endfunction

    task automatic set_flags(input logic [3:0] f);
        flag_n_i = f[0]; flag_v_i = f[1]; flag_c_i = f[2]; flag_z_i = f[3];
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pcs [4];
        logic [15:0] held;
        pcs[0] = 16'h0000; pcs[1] = 16'h1234; pcs[2] = 16'h8000; pcs[3] = 16'hFFF0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset value", pc_q_o, 16'h0000);
        rst_n = 1'b1;

        // R4 R6: every selector against every flag combination
        pc_i = 16'h4000; offset_i = 8'h10;
        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 16; f++) begin
                @(negedge clk);
                sel_i = 3'(s); set_flags(4'(f));
                #1;
                check("R4 R6 taken", {15'h0, taken_o}, {15'h0, model_taken(3'(s), 4'(f))});
                check(model_taken(3'(s), 4'(f)) ? "R1 taken target" : "R5 not taken pc",
                      next_pc_o,
                      model_taken(3'(s), 4'(f)) ? 16'h4010 : 16'h4000);
            end
        end

        // R1 R2 R3: all offsets at four counters, taken (sel N-set, N=1)
        sel_i = 3'b001; set_flags(4'b0001);
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 256; o++) begin
                @(negedge clk);
                pc_i = pcs[p]; offset_i = 8'(o);
                #1;
                check(o >= 128 ? "R2 backward target" : "R1 R3 target",
                      next_pc_o, model_target(pcs[p], 8'(o)));
            end
        end

        // R3 explicit wrap corners
        @(negedge clk); pc_i = 16'hFFF0; offset_i = 8'h20; #1;
        check("R3 wrap up", next_pc_o, 16'h0010);
        @(negedge clk); pc_i = 16'h0000; offset_i = 8'hFF; #1;
        check("R3 wrap down", next_pc_o, 16'hFFFF);

        // R5: not taken across offsets (sel N-clear, N=1)
        sel_i = 3'b000;
        for (int o = 0; o < 256; o += 17) begin
            @(negedge clk); pc_i = 16'h2345; offset_i = 8'(o); #1;
            check("R5 not taken pc", next_pc_o, 16'h2345);
        end

        // R7: valid load of a taken target
        @(negedge clk);
        sel_i = 3'b111; set_flags(4'b1000); pc_i = 16'h0300; offset_i = 8'hF0;
        valid_i = 1'b1;
        @(posedge clk); #1;
        check("R7 load taken", pc_q_o, 16'h02F0);

        // R8: no valid, inputs change, register holds
        @(negedge clk);
        valid_i = 1'b0; pc_i = 16'h7777; offset_i = 8'h05;
        held = 16'h02F0;
        repeat (3) begin
            @(posedge clk); #1;
            check("R8 hold", pc_q_o, held);
        end

        // R7 R5: valid load when not taken stores pc
        @(negedge clk);
        sel_i = 3'b110; set_flags(4'b1000); pc_i = 16'hABCD; offset_i = 8'h40;
        valid_i = 1'b1;
        @(posedge clk); #1;
        check("R7 R5 load not taken", pc_q_o, 16'hABCD);
        @(negedge clk); valid_i = 1'b0;

        // R9: reset again
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9 reset reload", pc_q_o, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule